// File: doc/BRIEF.md
# Serial Program/Verify Target Port

This block is the device-side end of a two-wire serial programming link. An external programmer toggles a serial clock and either drives or samples a shared data line. The block decodes six-bit commands and exchanges fourteen-bit words with a program memory model that sits behind a program counter. It can load a data latch, return the word at the current address, step the address, start or end a write, and erase the whole array.

The serial clock and data are oversampled in the system clock domain through a short synchronizer. Every action happens a few system clocks after the serial edge that causes it, so the serial half period must be longer than the synchronizer depth plus two system clocks. Program/verify mode is a single synchronous enable. While it is high, the rest of the device is held in reset. The data line is driven only inside the data frame of a read. A write is modelled as a flash cell: it can only clear bits, it finishes after a fixed number of system clocks, and it can be ended early by command.

Top module: `ser_prog_port`

## Requirements
- R1: A command is six bits, shifted in least significant bit first, with each bit taken on a falling edge of `sclk`. Only bits [3:0] are decoded and bits [5:4] are ignored. The codes are: read 0x4, load 0x2, step address 0x6, erase all 0x9, begin write 0x8, end write 0xE.
- R2: A load command is followed by a 16-clock data frame. The bits taken on the falling edges of clocks 2 to 15 form the latch word, least significant bit first. Data on clocks 1 and 16 is ignored, and the latch is updated when the frame ends.
- R3: A read command is followed by a 16-clock data frame carrying the word stored at the program counter when the command ended. `sdat_oe` rises on the rising edge of clock 2. Bit k is presented on `sdat_out` from the rising edge of clock k+2. `sdat_oe` falls on the rising edge of clock 16.
- R4: Each entry into the mode presets the program counter to 2^ADDR_W-1. This is 0x3FF by default and 0x7FF when WIDE_MAP=1. Step address adds one and wraps from the top address to 0.
- R5: Begin write captures the current address. PROG_CYCLES system clocks later, the word at that address becomes its old value AND the latch, so a write only clears bits.
- R6: End write commits a pending write at once.
- R7: Erase all sets every word to 0x3FFF and cancels any pending write.
- R8: A code outside the six listed has no effect on the counter, the memory or the latch, and the next six clocks form a new command.
- R9: `core_hold` equals `prog_en`. While `prog_en` is low, `sdat_oe` is low and serial clocks are ignored.
- R10: Dropping `prog_en` part-way through a command or data frame discards the partial frame. After re-entry, the next six clocks form a command.
- R11: While `rst_n` is low, `sdat_oe` and `sdat_out` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Program/verify mode enable, synchronous to clk |
| sclk | input | 1 | Serial clock from the programmer |
| sdat_in | input | 1 | Serial data as seen at the pin |
| sdat_out | output | 1 | Serial read data |
| sdat_oe | output | 1 | Output enable for the data pin |
| core_hold | output | 1 | Holds the rest of the device in reset while in the mode |

## Verification
The checker watches the frame timing on every cycle. Command and load strobes may only follow a falling serial edge. The output enable may only change on a rising serial edge or on mode exit. Nothing is driven or strobed while the mode is off, and no command completes while the pin is driven. The bench's scenarios show what those properties cannot see: data values and bit order, the counter preset and wrap, the clear-only write and its timed or early commit, erase, ignored codes, and frame discard across exit and re-entry.

// File: rtl/ser_prog_pkg.sv
package ser_prog_pkg;
  localparam int CMD_W = 6;
  localparam int OP_W  = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'b0010;
  localparam logic [OP_W-1:0] OP_READ  = 4'b0100;
  localparam logic [OP_W-1:0] OP_STEP  = 4'b0110;
  localparam logic [OP_W-1:0] OP_BEGIN = 4'b1000;
  localparam logic [OP_W-1:0] OP_END   = 4'b1110;
  localparam logic [OP_W-1:0] OP_ERASE = 4'b1001;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_LOAD = 2'd1,
    PH_READ = 2'd2
  } phase_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sclk,
  input  logic sdat,
  output logic rise,
  output logic fall,
  output logic dat
);
  logic [STAGES:0]   ck_q;
  logic [STAGES-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      d_q  <= '0;
    end else begin
      ck_q <= (STAGES+1)'({ck_q, sclk});
      d_q  <= STAGES'({d_q, sdat});
    end
  end

  // index STAGES-1 is the synchronized sample, index STAGES the one before
  assign rise = en &  ck_q[STAGES-1] & ~ck_q[STAGES];
  assign fall = en & ~ck_q[STAGES-1] &  ck_q[STAGES];
  assign dat  = d_q[STAGES-1];
endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_prog_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  input  logic [DATA_W-1:0] rd_word,
  output logic              cmd_stb,
  output logic [OP_W-1:0]   cmd_code,
  output logic              ld_stb,
  output logic [DATA_W-1:0] ld_word,
  output logic              dout,
  output logic              doe
);
  localparam int FRAME_CLKS = DATA_W + 2;
  localparam int FW         = $clog2(FRAME_CLKS + 1);
  localparam logic [FW-1:0] K_FIRST = FW'(2);
  localparam logic [FW-1:0] K_LAST  = FW'(FRAME_CLKS - 1);
  localparam logic [FW-1:0] K_END   = FW'(FRAME_CLKS);
  localparam logic [FW-1:0] K_CMD   = FW'(CMD_W);

  phase_e            phase_q, phase_d;
  logic [FW-1:0]     fcnt_q, fcnt_d;
  logic [FW-1:0]     rcnt_q, rcnt_d;
  logic [CMD_W-1:0]  csr_q, csr_d;
  logic [DATA_W-1:0] isr_q, isr_d;
  logic [DATA_W-1:0] osr_q, osr_d;
  logic [OP_W-1:0]   code_q, code_d;
  logic              doe_q, doe_d;
  logic              dout_q, dout_d;
  logic              cstb_q, cstb_d;
  logic              lstb_q, lstb_d;

  always_comb begin
    phase_d = phase_q;
    fcnt_d  = fcnt_q;
    rcnt_d  = rcnt_q;
    csr_d   = csr_q;
    isr_d   = isr_q;
    osr_d   = osr_q;
    code_d  = code_q;
    doe_d   = doe_q;
    dout_d  = dout_q;
    cstb_d  = 1'b0;
    lstb_d  = 1'b0;
    if (!en) begin
      phase_d = PH_CMD;
      fcnt_d  = '0;
      rcnt_d  = '0;
      doe_d   = 1'b0;
      dout_d  = 1'b0;
    end else begin
      if (rise && phase_q != PH_CMD) begin
        rcnt_d = rcnt_q + 1'b1;
        if (phase_q == PH_READ) begin
          if (rcnt_d >= K_FIRST && rcnt_d <= K_LAST) begin
            doe_d  = 1'b1;
            dout_d = osr_q[0];
            osr_d  = osr_q >> 1;
          end else if (rcnt_d == K_END) begin
            doe_d  = 1'b0;
            dout_d = 1'b0;
          end
        end
      end
      if (fall) begin
        fcnt_d = fcnt_q + 1'b1;
        if (phase_q == PH_CMD) begin
          csr_d = {din, csr_q[CMD_W-1:1]};
          if (fcnt_d == K_CMD) begin
            fcnt_d = '0;
            rcnt_d = '0;
            cstb_d = 1'b1;
            code_d = csr_d[OP_W-1:0];
            if (code_d == OP_LOAD) begin
              phase_d = PH_LOAD;
            end else if (code_d == OP_READ) begin
              phase_d = PH_READ;
              osr_d   = rd_word;
            end
          end
        end else begin
          if (phase_q == PH_LOAD && fcnt_d >= K_FIRST && fcnt_d <= K_LAST) begin
            isr_d = {din, isr_q[DATA_W-1:1]};
          end
          if (fcnt_d == K_END) begin
            fcnt_d  = '0;
            rcnt_d  = '0;
            phase_d = PH_CMD;
            lstb_d  = (phase_q == PH_LOAD);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      fcnt_q  <= '0;
      rcnt_q  <= '0;
      csr_q   <= '0;
      isr_q   <= '0;
      osr_q   <= '0;
      code_q  <= '0;
      doe_q   <= 1'b0;
      dout_q  <= 1'b0;
      cstb_q  <= 1'b0;
      lstb_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fcnt_q  <= fcnt_d;
      rcnt_q  <= rcnt_d;
      csr_q   <= csr_d;
      isr_q   <= isr_d;
      osr_q   <= osr_d;
      code_q  <= code_d;
      doe_q   <= doe_d;
      dout_q  <= dout_d;
      cstb_q  <= cstb_d;
      lstb_q  <= lstb_d;
    end
  end

  assign cmd_stb  = cstb_q;
  assign cmd_code = code_q;
  assign ld_stb   = lstb_q;
  assign ld_word  = isr_q;
  assign dout     = dout_q;
  assign doe      = doe_q;
endmodule

// File: rtl/prog_store.sv
module prog_store
  import ser_prog_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 14,
  parameter int PROG_CYCLES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cmd_stb,
  input  logic [OP_W-1:0]   cmd_code,
  input  logic              ld_stb,
  input  logic [DATA_W-1:0] ld_word,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [DATA_W-1:0] lat_q, lat_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              busy_q, busy_d;
  logic              en_q;
  logic              commit, erase;

  always_comb begin
    pc_d   = pc_q;
    wa_d   = wa_q;
    lat_d  = lat_q;
    tmr_d  = tmr_q;
    busy_d = busy_q;
    commit = 1'b0;
    erase  = 1'b0;
    if (!en) begin
      busy_d = 1'b0;
    end else begin
      if (!en_q) pc_d = '1;
      if (busy_q) begin
        if (tmr_q == '0) begin
          commit = 1'b1;
          busy_d = 1'b0;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      if (ld_stb) lat_d = ld_word;
      if (cmd_stb) begin
        case (cmd_code)
          OP_STEP:  pc_d = pc_q + 1'b1;
          OP_BEGIN: begin
            busy_d = 1'b1;
            tmr_d  = TW'(PROG_CYCLES - 1);
            wa_d   = pc_q;
          end
          OP_END: begin
            if (busy_q && !commit) begin
              commit = 1'b1;
              busy_d = 1'b0;
            end
          end
          OP_ERASE: begin
            erase  = 1'b1;
            commit = 1'b0;
            busy_d = 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '1;
      wa_q   <= '0;
      lat_q  <= '1;
      tmr_q  <= '0;
      busy_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      wa_q   <= wa_d;
      lat_q  <= lat_d;
      tmr_q  <= tmr_d;
      busy_q <= busy_d;
      en_q   <= en;
    end
  end

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      mem[wa_q] <= mem[wa_q] & lat_q;
    end
  end

  assign rd_word = mem[pc_q];
endmodule

// File: rtl/ser_prog_port.sv
module ser_prog_port
  import ser_prog_pkg::*;
#(
  parameter bit WIDE_MAP    = 1'b0,
  parameter int PROG_CYCLES = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_en,
  input  logic sclk,
  input  logic sdat_in,
  output logic sdat_out,
  output logic sdat_oe,
  output logic core_hold
);
  localparam int ADDR_W = WIDE_MAP ? 11 : 10;
  localparam int DATA_W = 14;

  logic              sclk_rise, sclk_fall, din_s;
  logic              cmd_stb, ld_stb;
  logic [OP_W-1:0]   cmd_code;
  logic [DATA_W-1:0] ld_word, rd_word;

  ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(prog_en),
    .sclk(sclk), .sdat(sdat_in),
    .rise(sclk_rise), .fall(sclk_fall), .dat(din_s)
  );

  ser_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(prog_en),
    .rise(sclk_rise), .fall(sclk_fall), .din(din_s),
    .rd_word(rd_word),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .ld_stb(ld_stb), .ld_word(ld_word),
    .dout(sdat_out), .doe(sdat_oe)
  );

  prog_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .en(prog_en),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .ld_stb(ld_stb), .ld_word(ld_word),
    .rd_word(rd_word)
  );

  assign core_hold = prog_en;
endmodule

// File: rtl/ser_prog_port_chk.sv
module ser_prog_port_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_en,
  input logic rise,
  input logic fall,
  input logic cmd_stb,
  input logic ld_stb,
  input logic sdat_oe
);
  // R1
  cmd_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(fall));

  // R1
  no_cmd_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> !sdat_oe);

  // R2
  load_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> ($past(fall) && !sdat_oe));

  // R3
  oe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> $past(rise));

  // R3
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdat_oe) |-> ($past(rise) || !$past(prog_en)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> (!sdat_oe && !cmd_stb && !ld_stb));
endmodule

bind ser_prog_port ser_prog_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
  .rise(sclk_rise), .fall(sclk_fall),
  .cmd_stb(cmd_stb), .ld_stb(ld_stb), .sdat_oe(sdat_oe)
);

// File: tb/ser_prog_port_test.sv
module ser_prog_port_test;
  localparam int HALF  = 6;
  localparam int PROG  = 512;
  localparam int MAXPC = 1023;
  localparam logic [5:0] C_LOAD  = 6'b000010;
  localparam logic [5:0] C_READ  = 6'b000100;
  localparam logic [5:0] C_STEP  = 6'b000110;
  localparam logic [5:0] C_BEGIN = 6'b001000;
  localparam logic [5:0] C_END   = 6'b001110;
  localparam logic [5:0] C_ERASE = 6'b001001;

  logic clk = 1'b0;
  logic rst_n, prog_en, sclk, sdat_in;
  logic sdat_out, sdat_oe, core_hold;

  always #10 clk = ~clk;

  ser_prog_port #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sclk(sclk),
    .sdat_in(sdat_in), .sdat_out(sdat_out), .sdat_oe(sdat_oe),
    .core_hold(core_hold)
  );

  int compared = 0;
  int mismatched = 0;
  int since_edge = 0;
  bit done = 1'b0;
  bit exp_oe = 1'b0;
  bit exp_out = 1'b0;

  logic [13:0] mdl [MAXPC+1];
  int mpc = MAXPC;
  logic [13:0] mlat = 14'h3FFF;

  task automatic cmp(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison once the last serial edge has settled
  always @(negedge clk) begin
    if (rst_n && !done) begin
      since_edge++;
      if (since_edge >= 5) begin
        cmp("R9", "core_hold", int'(core_hold), int'(prog_en));
        cmp("R3", "sdat_oe", int'(sdat_oe), int'(exp_oe));
        if (exp_oe) cmp("R3", "sdat_out", int'(sdat_out), int'(exp_out));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    sdat_in = b; sclk = 1'b1; since_edge = 0; tick(HALF);
    sclk = 1'b0; since_edge = 0; tick(HALF);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) clk_bit(c[i]);
    case (c[3:0])
      4'h6: mpc = (mpc + 1) % (MAXPC + 1);
      4'h9: for (int i = 0; i <= MAXPC; i++) mdl[i] = 14'h3FFF;
      default: ;
    endcase
  endtask

  task automatic load(input logic [13:0] w);
    send_cmd(C_LOAD);
    clk_bit(1'b1);
    for (int i = 0; i < 14; i++) clk_bit(w[i]);
    clk_bit(1'b1);
    mlat = w;
  endtask

  task automatic program_word(input logic [13:0] w);
    load(w);
    send_cmd(C_BEGIN);
    tick(PROG + 20);
    mdl[mpc] = mdl[mpc] & mlat;
  endtask

  task automatic read_chk(input string req, input logic [5:0] code);
    logic [13:0] want;
    logic [13:0] got;
    want = mdl[mpc];
    got = '0;
    send_cmd(code);
    sdat_in = 1'b0;
    for (int n = 1; n <= 16; n++) begin
      sclk = 1'b1; since_edge = 0;
      if (n == 2) exp_oe = 1'b1;
      if (n >= 2 && n <= 15) exp_out = want[n-2];
      if (n == 16) exp_oe = 1'b0;
      tick(HALF);
      if (n >= 2 && n <= 15) got[n-2] = sdat_out;
      sclk = 1'b0; since_edge = 0; tick(HALF);
    end
    cmp(req, "read word", int'(got), int'(want));
  endtask

  task automatic set_mode(input logic v);
    prog_en = v; since_edge = 0;
    if (!v) exp_oe = 1'b0;
    if (v) mpc = MAXPC;
    tick(8);
  endtask

  initial begin
    rst_n = 1'b0; prog_en = 1'b0; sclk = 1'b0; sdat_in = 1'b0;
    tick(4);
    // R11 reset state
    cmp("R11", "sdat_oe in reset", int'(sdat_oe), 0);
    cmp("R11", "sdat_out in reset", int'(sdat_out), 0);
    cmp("R9", "core_hold idle", int'(core_hold), 0);
    rst_n = 1'b1;
    tick(4);
    // R9 serial clocks ignored while the mode is off
    for (int i = 0; i < 6; i++) clk_bit(C_READ[i]);
    for (int i = 0; i < 4; i++) clk_bit(1'b0);
    cmp("R9", "oe while off", int'(sdat_oe), 0);

    set_mode(1'b1);
    cmp("R9", "core_hold in mode", int'(core_hold), 1);
    send_cmd(C_ERASE);
    read_chk("R7 R4 erased top word", C_READ);
    program_word(14'h1234);
    read_chk("R5 R2 timed write", C_READ);
    program_word(14'h0FF0);
    read_chk("R5 clear-only write", C_READ);

    // R4 wrap to address 0
    send_cmd(C_STEP);
    read_chk("R4 wrap to zero", C_READ);

    // R8 unknown codes keep latch, then R6 early end
    load(14'h2AAA);
    send_cmd(6'b000000);
    send_cmd(6'b001111);
    send_cmd(C_BEGIN);
    send_cmd(C_END);
    mdl[mpc] = mdl[mpc] & mlat;
    read_chk("R6 R8 early commit", C_READ);
    // R1 upper two bits ignored
    read_chk("R1 upper bits ignored", 6'b110100);

    // R10 partial command discarded across exit
    clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1);
    set_mode(1'b0);
    cmp("R9", "core_hold after exit", int'(core_hold), 0);
    set_mode(1'b1);
    read_chk("R10 R4 re-entry after partial cmd", C_READ);

    // R10 partial load discarded, latch kept
    send_cmd(C_LOAD);
    for (int i = 0; i < 7; i++) clk_bit(1'b0);
    set_mode(1'b0);
    set_mode(1'b1);
    send_cmd(C_STEP);
    send_cmd(C_STEP);
    send_cmd(C_BEGIN);
    tick(PROG + 20);
    mdl[mpc] = mdl[mpc] & mlat;
    read_chk("R10 R2 latch survives partial load", C_READ);

    // R9 exit in the middle of a read frame releases the pin
    send_cmd(C_READ);
    for (int n = 1; n <= 5; n++) begin
      sclk = 1'b1; since_edge = 0;
      if (n == 2) exp_oe = 1'b1;
      if (n >= 2) exp_out = mdl[mpc][n-2];
      tick(HALF);
      sclk = 1'b0; since_edge = 0; tick(HALF);
    end
    cmp("R3", "oe inside read frame", int'(sdat_oe), 1);
    set_mode(1'b0);
    cmp("R9", "oe after exit mid read", int'(sdat_oe), 0);
    set_mode(1'b1);

    // R7 erase cancels a pending write
    load(14'h0000);
    send_cmd(C_BEGIN);
    send_cmd(C_ERASE);
    tick(PROG + 20);
    read_chk("R7 erase cancels write", C_READ);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule